// File: doc/BRIEF.md
# Long-Branch Interrupt Vector Responder

This block answers a processor's interrupt acknowledge. It supplies a complete three-byte long-branch instruction, one byte on each consecutive instruction fetch aimed at it. The first byte is the branch opcode 0xC0. The second byte is a programmable page byte, which is the high half of the target address. The third byte is a low address byte. That low byte merges programmed upper bits with the index of the highest active request level, scaled by a selectable service-routine spacing of 2, 4, 8 or 16 bytes.

The level index comes from a separate request unit, together with a flag that says whether any unmasked request is pending. The responder captures the index on the opcode fetch and uses it for the rest of the sequence. On that same fetch it pulses a clear strobe that carries the serviced level back to the request unit. Software can also poll the block. A poll read returns the low vector byte for the level that is active right now, without starting or advancing a fetch sequence.

Top module: `lbr_vec_gen`

## Requirements
- R1: After synchronous reset: `rdata` = 0, `rdata_valid` = 0, `clr_pulse` = 0, page = 0, programmed upper nibble = 0, spacing code = 0. The first fetch after reset returns byte one of the sequence.
- R2: A fetch at sequence position one returns 0xC0 on `rdata` in the cycle after the fetch.
- R3: A fetch at position two returns the page byte. The page byte is the `wdata` value last loaded through `page_wr`.
- R4: A fetch at position three returns the low byte. A `ctrl_wr` write stores `wdata[7:4]` as the upper nibble U and `wdata[1:0]` as the spacing code S. With L the captured level, the low byte is:
  - S=0 (2 bytes): {U[3:0], L, 0}
  - S=1 (4 bytes): {U[3:1], L, 00}
  - S=2 (8 bytes): {U[3:2], L, 000}
  - S=3 (16 bytes): {U[3], L, 0000}
- R5: The level is captured on the position-one fetch. Positions two and three ignore later changes of `req_level` and `req_valid`.
- R6: On a position-one fetch with `req_valid` = 1, `clr_pulse` is high for exactly one cycle (the next), and `clr_level` carries the captured level. No other fetch pulses it.
- R7: On a position-one fetch with `req_valid` = 0, the captured level is 0 and `clr_pulse` stays low.
- R8: The fetch after position three starts again at position one (0xC0).
- R9: A poll read (`poll_rd` without `fetch`) returns the R4 low byte built from the current level, or level 0 when `req_valid` = 0. It does not move the sequence position.
- R10: When `fetch` and `poll_rd` are high in the same cycle, the fetch is served and the poll is ignored.
- R11: `rdata_valid` is high exactly in the cycle after a fetch or poll. Otherwise `rdata` holds its last value.
- R12: A register write in the same cycle as a fetch takes effect one cycle later. That fetch returns the old page or low byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| page_wr | input | 1 | Load page byte from wdata |
| ctrl_wr | input | 1 | Load upper nibble and spacing code from wdata |
| wdata | input | 8 | Write data |
| fetch | input | 1 | Instruction fetch of the next response byte |
| poll_rd | input | 1 | Polling read of the low vector byte |
| req_valid | input | 1 | An unmasked request is pending |
| req_level | input | 3 | Index of the highest active request |
| rdata | output | 8 | Registered read data |
| rdata_valid | output | 1 | rdata was loaded by the previous cycle's access |
| clr_pulse | output | 1 | One-cycle clear strobe for the serviced level |
| clr_level | output | 3 | Level to clear, valid with clr_pulse |

## Verification
Two kinds of function can land in the same cycle. The first is a fetch together with a poll read. The second is a fetch together with a write to the page or control byte. Directed cycles force a fetch-plus-poll at position one and writes during the page and low-byte fetches. A random phase then mixes all four strobes freely. A bench model judges each returned byte from the state before the edge: fetch wins over poll, and a write is seen only by later fetches.

// File: rtl/lbr_pkg.sv
`timescale 1ns/1ps
package lbr_pkg;
  typedef enum logic [1:0] {
    POS_OP = 2'd0,
    POS_HI = 2'd1,
    POS_LO = 2'd2
  } resp_pos_e;

  localparam logic [7:0] LBR_OPCODE = 8'hC0;
endpackage

// File: rtl/lbr_cfg_regs.sv
`timescale 1ns/1ps
module lbr_cfg_regs #(
  parameter int DATA_W = 8,
  parameter int UP_W   = 4,
  parameter int SEL_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              page_wr,
  input  logic              ctrl_wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] page_q,
  output logic [UP_W-1:0]   up_q,
  output logic [SEL_W-1:0]  sel_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      page_q <= '0;
      up_q   <= '0;
      sel_q  <= '0;
    end else begin
      if (page_wr) page_q <= wdata;
      if (ctrl_wr) begin
        up_q  <= wdata[DATA_W-1 -: UP_W];
        sel_q <= wdata[SEL_W-1:0];
      end
    end
  end
endmodule

// File: rtl/lbr_low_vec.sv
`timescale 1ns/1ps
module lbr_low_vec #(
  parameter int DATA_W = 8,
  parameter int IDX_W  = 3,
  parameter int UP_W   = 4,
  parameter int SEL_W  = 2
) (
  input  logic [UP_W-1:0]   up,
  input  logic [SEL_W-1:0]  sel,
  input  logic [IDX_W-1:0]  level,
  output logic [DATA_W-1:0] low
);
  localparam int BASE_SH = DATA_W - UP_W;

  logic [DATA_W-1:0] up_full;
  logic [DATA_W-1:0] keep_mask;
  logic [DATA_W-1:0] idx_part;

  assign up_full = {up, {BASE_SH{1'b0}}};

  // Each bit is either programmed or supplied by the scaled level index.
  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    assign keep_mask[b] = (b >= (BASE_SH + int'(sel)));
  end

  assign idx_part = DATA_W'(level) << (int'(sel) + 1);
  assign low      = (up_full & keep_mask) | (idx_part & ~keep_mask);
endmodule

// File: rtl/lbr_seq.sv
`timescale 1ns/1ps
module lbr_seq
  import lbr_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fetch,
  input  logic              poll_rd,
  input  logic              req_valid,
  input  logic [IDX_W-1:0]  live_level,
  input  logic [DATA_W-1:0] page_q,
  input  logic [DATA_W-1:0] fetch_low,
  input  logic [DATA_W-1:0] poll_low,
  output logic [IDX_W-1:0]  cap_level,
  output logic [DATA_W-1:0] rdata,
  output logic              rdata_valid,
  output logic              clr_pulse,
  output logic [IDX_W-1:0]  clr_level
);
  resp_pos_e pos_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q       <= POS_OP;
      cap_level   <= '0;
      rdata       <= '0;
      rdata_valid <= 1'b0;
      clr_pulse   <= 1'b0;
      clr_level   <= '0;
    end else begin
      rdata_valid <= fetch | poll_rd;
      clr_pulse   <= 1'b0;
      if (fetch) begin
        unique case (pos_q)
          POS_OP: begin
            rdata     <= DATA_W'(LBR_OPCODE);
            cap_level <= live_level;
            clr_pulse <= req_valid;
            if (req_valid) clr_level <= live_level;
            pos_q     <= POS_HI;
          end
          POS_HI: begin
            rdata <= page_q;
            pos_q <= POS_LO;
          end
          POS_LO: begin
            rdata <= fetch_low;
            pos_q <= POS_OP;
          end
          default: pos_q <= POS_OP;
        endcase
      end else if (poll_rd) begin
        rdata <= poll_low;
      end
    end
  end
endmodule

// File: rtl/lbr_vec_gen.sv
`timescale 1ns/1ps
module lbr_vec_gen #(
  parameter int DATA_W = 8,
  parameter int LEVELS = 8,
  parameter int SEL_W  = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      page_wr,
  input  logic                      ctrl_wr,
  input  logic [DATA_W-1:0]         wdata,
  input  logic                      fetch,
  input  logic                      poll_rd,
  input  logic                      req_valid,
  input  logic [$clog2(LEVELS)-1:0] req_level,
  output logic [DATA_W-1:0]         rdata,
  output logic                      rdata_valid,
  output logic                      clr_pulse,
  output logic [$clog2(LEVELS)-1:0] clr_level
);
  localparam int IDX_W = $clog2(LEVELS);
  localparam int UP_W  = DATA_W - IDX_W - 1;

  logic [DATA_W-1:0] page_q;
  logic [UP_W-1:0]   up_q;
  logic [SEL_W-1:0]  sel_q;
  logic [IDX_W-1:0]  live_level;
  logic [IDX_W-1:0]  cap_level;
  logic [DATA_W-1:0] fetch_low;
  logic [DATA_W-1:0] poll_low;

  assign live_level = req_valid ? req_level : '0;

  lbr_cfg_regs #(.DATA_W(DATA_W), .UP_W(UP_W), .SEL_W(SEL_W)) u_cfg (
    .clk(clk), .rst(rst), .page_wr(page_wr), .ctrl_wr(ctrl_wr),
    .wdata(wdata), .page_q(page_q), .up_q(up_q), .sel_q(sel_q)
  );

  lbr_low_vec #(.DATA_W(DATA_W), .IDX_W(IDX_W), .UP_W(UP_W), .SEL_W(SEL_W)) u_fetch_low (
    .up(up_q), .sel(sel_q), .level(cap_level), .low(fetch_low)
  );

  lbr_low_vec #(.DATA_W(DATA_W), .IDX_W(IDX_W), .UP_W(UP_W), .SEL_W(SEL_W)) u_poll_low (
    .up(up_q), .sel(sel_q), .level(live_level), .low(poll_low)
  );

  lbr_seq #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_seq (
    .clk(clk), .rst(rst), .fetch(fetch), .poll_rd(poll_rd),
    .req_valid(req_valid), .live_level(live_level), .page_q(page_q),
    .fetch_low(fetch_low), .poll_low(poll_low), .cap_level(cap_level),
    .rdata(rdata), .rdata_valid(rdata_valid), .clr_pulse(clr_pulse),
    .clr_level(clr_level)
  );
endmodule

// File: rtl/lbr_vec_gen_chk.sv
`timescale 1ns/1ps
module lbr_vec_gen_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              fetch,
  input logic              poll_rd,
  input logic              req_valid,
  input logic [DATA_W-1:0] rdata,
  input logic              rdata_valid,
  input logic              clr_pulse
);
  logic [1:0] pos_cnt;

  always_ff @(posedge clk) begin
    if (rst) pos_cnt <= 2'd0;
    else if (fetch) pos_cnt <= (pos_cnt == 2'd2) ? 2'd0 : pos_cnt + 2'd1;
  end

  assert_valid_follows_R11: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (rdata_valid == $past(fetch || poll_rd)));

  assert_opcode_first_R2: assert property (@(posedge clk) disable iff (rst)
    (fetch && pos_cnt == 2'd0) |=> (rdata == DATA_W'(8'hC0)));

  assert_fetch_beats_poll_R10: assert property (@(posedge clk) disable iff (rst)
    (fetch && poll_rd && pos_cnt == 2'd0) |=> (rdata == DATA_W'(8'hC0)));

  assert_clr_on_first_R6: assert property (@(posedge clk) disable iff (rst)
    (fetch && pos_cnt == 2'd0 && req_valid) |=> clr_pulse);

  assert_clr_only_first_R6: assert property (@(posedge clk) disable iff (rst)
    clr_pulse |-> ($past(fetch) && $past(pos_cnt) == 2'd0));

  assert_no_clr_idle_R7: assert property (@(posedge clk) disable iff (rst)
    (fetch && pos_cnt == 2'd0 && !req_valid) |=> !clr_pulse);
endmodule

bind lbr_vec_gen lbr_vec_gen_chk #(.DATA_W(DATA_W)) i_chk (
  .clk(clk), .rst(rst), .fetch(fetch), .poll_rd(poll_rd),
  .req_valid(req_valid), .rdata(rdata), .rdata_valid(rdata_valid),
  .clr_pulse(clr_pulse)
);

// File: tb/test_lbr_vec_gen.sv
`timescale 1ns/1ps
module test_lbr_vec_gen;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       page_wr = 0, ctrl_wr = 0, fetch = 0, poll_rd = 0, req_valid = 0;
  logic [7:0] wdata = '0;
  logic [2:0] req_level = '0;
  logic [7:0] rdata;
  logic       rdata_valid, clr_pulse;
  logic [2:0] clr_level;

  int n_checks = 0, n_fail = 0;
  bit done = 0;

  // model state
  logic [7:0] m_page = 0;
  logic [3:0] m_up = 0;
  logic [1:0] m_sel = 0;
  logic [2:0] m_cap = 0;
  int         m_pos = 0;
  int         m_seqs = 0;
  logic [7:0] m_data = 0;

  always #5 clk = ~clk;

  lbr_vec_gen i_lbr_vec_gen (
    .clk(clk), .rst(rst), .page_wr(page_wr), .ctrl_wr(ctrl_wr), .wdata(wdata),
    .fetch(fetch), .poll_rd(poll_rd), .req_valid(req_valid), .req_level(req_level),
    .rdata(rdata), .rdata_valid(rdata_valid), .clr_pulse(clr_pulse), .clr_level(clr_level)
  );

  function automatic logic [7:0] exp_low(logic [3:0] up, logic [1:0] sel, logic [2:0] lv);
    case (sel)
      2'd0:    return {up, lv, 1'b0};
      2'd1:    return {up[3:1], lv, 2'b00};
      2'd2:    return {up[3:2], lv, 3'b000};
      default: return {up[3], lv, 4'b0000};
    endcase
  endfunction

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc(bit f, bit p, bit pw, bit cw, logic [7:0] wd,
                     bit rv, logic [2:0] rl, string hint);
    logic [7:0] e_data;
    bit         e_valid, e_clr;
    logic [2:0] e_lvl;
    string      tag;
    @(negedge clk);
    fetch = f; poll_rd = p; page_wr = pw; ctrl_wr = cw; wdata = wd;
    req_valid = rv; req_level = rl;
    e_data = m_data; e_valid = f | p; e_clr = 0; e_lvl = rv ? rl : 3'd0;
    tag = "R11";
    if (f) begin
      case (m_pos)
        0: begin
          e_data = 8'hC0; m_cap = e_lvl; e_clr = rv;
          tag = !rv ? "R7" : (m_seqs > 0 ? "R8" : "R2");
        end
        1: begin e_data = m_page; tag = "R3"; end
        default: begin e_data = exp_low(m_up, m_sel, m_cap); tag = "R4"; end
      endcase
      if (p) tag = "R10";
      else if (pw || cw) tag = "R12";
      if (m_pos == 2) m_seqs++;
      m_pos = (m_pos + 1) % 3;
    end else if (p) begin
      e_data = exp_low(m_up, m_sel, e_lvl); tag = "R9";
    end
    if (hint != "") tag = hint;
    @(posedge clk); #1;
    check(tag, rdata, e_data);
    check("R11", {7'd0, rdata_valid}, {7'd0, e_valid});
    check("R6", {7'd0, clr_pulse}, {7'd0, e_clr});
    if (e_clr) check("R6", {5'd0, clr_level}, {5'd0, e_lvl});
    m_data = e_data;
    if (pw) m_page = wd;
    if (cw) begin m_up = wd[7:4]; m_sel = wd[1:0]; end
    @(negedge clk);
    fetch = 0; poll_rd = 0; page_wr = 0; ctrl_wr = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    int seed_val;
    seed_val = $urandom(32'd2024);
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    #1;
    check("R1", rdata, 8'h00);
    check("R1", {6'd0, rdata_valid, clr_pulse}, 8'h00);

    cyc(0, 0, 1, 0, 8'h5A, 0, 0, "R3");
    cyc(0, 0, 0, 1, 8'hB1, 0, 0, "R4");
    cyc(1, 0, 0, 0, 8'h00, 1, 3'd5, "R1");
    cyc(1, 0, 0, 0, 8'h00, 1, 3'd6, "R3");
    cyc(1, 0, 0, 0, 8'h00, 1, 3'd7, "R5");
    check("R5", m_data, 8'hB4);
    cyc(1, 0, 0, 0, 8'h00, 1, 3'd2, "R8");
    cyc(0, 0, 0, 0, 8'h00, 1, 3'd2, "R11");
    cyc(0, 1, 0, 0, 8'h00, 1, 3'd3, "R9");
    cyc(1, 0, 1, 0, 8'h33, 1, 3'd3, "R12");
    cyc(1, 0, 0, 1, 8'h73, 0, 3'd4, "R12");
    cyc(1, 1, 0, 0, 8'h00, 0, 3'd4, "R10");
    cyc(1, 0, 0, 0, 8'h00, 0, 3'd4, "R3");
    cyc(1, 0, 0, 0, 8'h00, 1, 3'd6, "R7");

    for (int s = 0; s < 4; s++) begin
      cyc(0, 0, 0, 1, {4'hF - 4'(s), 2'b10, 2'(s)}, 0, 0, "R4");
      cyc(1, 0, 0, 0, 8'h00, 1, 3'(s + 4), "R4");
      cyc(1, 0, 0, 0, 8'h00, 0, 0, "R3");
      cyc(1, 0, 0, 0, 8'h00, 0, 0, "R4");
      cyc(0, 1, 0, 0, 8'h00, 1, 3'd7, "R9");
    end

    for (int i = 0; i < 600; i++) begin
      cyc(($urandom % 3) == 0, ($urandom % 4) == 0, ($urandom % 8) == 0,
          ($urandom % 8) == 0, 8'($urandom), ($urandom % 4) != 0,
          3'($urandom), "");
    end

    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule